// File: doc/BRIEF.md
# Multi-Channel Edge-Compare PWM Generator with Staged Updates

The block drives up to sixteen pulse-width outputs from one shared time base. A prescaler divides the clock, and a period counter counts from zero to a programmed limit and then wraps. Every channel has a rise compare value and a fall compare value. A channel's output is high while the counter lies in the window between them. Software reaches every setting through a small synchronous register port with address, write data, write strobe and combinational read data.

A build-time mask gives some channels a staging copy of their compare values. On a staged channel, software writes new values into the staging copy. It then writes a one to the update register. At the next wrap of the period counter, every staged channel takes its new values in the same cycle, so a waveform never shows half an update. On a channel without staging, a compare write changes the waveform on the next clock, glitch or not. On a staged channel, reading a compare register returns the value that is driving the output, not the staged one.

Top module: `pwm_bank`

## Requirements
- R1: Reset clears every enable, compare value, staged value, period, prescale and the update flag, and sets the counters to zero. All reads return 0 and all outputs are 0.
- R2: Channel n is enabled by bit (n mod 8) of the enable register at address 0x00 (channels 0–7) or 0x01 (channels 8–15). A disabled channel drives 0.
- R3: With prescale P at address 0x03, the period counter advances once every P+1 clocks. It counts 0 up to the period value at address 0x02 and then returns to 0. The wrap cycle is the end of a period.
- R4: An enabled channel is high exactly while rise <= counter < fall. When rise equals fall the output stays low. Rise of channel n is at address 0x10+2n and fall is at 0x11+2n.
- R5: On a channel built without staging, a compare write takes effect on the output and on read-back from the next clock.
- R6: On a staged channel, a compare write changes neither the output nor the read-back value. With no update request it is never applied.
- R7: Writing data bit 0 = 1 to address 0x04 sets the update flag, which reads back as 1. At the next end of period, all staged channels copy their staged values together and the flag clears in that same cycle.
- R8: An update request is consumed by the first end of period after it. Compare values written after that commit stay staged until another request is written.
- R9: If an update request is written in an end-of-period cycle, it is kept for the following end of period. If a staged compare write coincides with a commit, the commit takes the value staged before that edge, and the new value waits.
- R10: Writing 0 in bit 0 to address 0x04 does not set the update flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Register address |
| wdata_i | input | CNT_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | CNT_W | Read data for addr_i, combinational |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
Two things can happen in the same cycle as the end-of-period commit. One is a fresh update request. The other is a write to a staged compare register. The bench predicts the wrap from its own model and places each of these writes exactly on that cycle. It then judges the result in two ways. It reads back the update flag and the active compare value straight after the edge. It also compares the outputs and read data with the model on every clock over the following periods. That shows the request waits one more period and the coinciding write is not committed.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_EN_LO    = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN_HI    = 6'h01;
  localparam logic [ADDR_W-1:0] A_PERIOD   = 6'h02;
  localparam logic [ADDR_W-1:0] A_PRESCALE = 6'h03;
  localparam logic [ADDR_W-1:0] A_SYNC     = 6'h04;
  localparam logic [ADDR_W-1:0] A_EDGE     = 6'h10;

  function automatic logic [ADDR_W-1:0] edge_addr(int unsigned ch, logic fall);
    return A_EDGE + ADDR_W'(ch * 2) + ADDR_W'(fall);
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] prescale_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eop_o
);
  logic [CNT_W-1:0] pre_q, cnt_q;
  logic tick, wrap;

  assign tick  = (pre_q >= prescale_i);
  assign wrap  = (cnt_q >= period_i);   // >= also recovers when period shrinks
  assign eop_o = tick && wrap;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> cnt_q == '0);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wrap) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W  = 16,
  parameter bit SHADOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_rise_i,
  input  logic             wr_fall_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] rise_o,
  output logic [CNT_W-1:0] fall_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] rise_q, fall_q;

  if (SHADOW) begin : g_shadow
    logic [CNT_W-1:0] rise_s, fall_s;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= '0;
        fall_q <= '0;
        rise_s <= '0;
        fall_s <= '0;
      end else begin
        if (commit_i) begin
          rise_q <= rise_s;
          fall_q <= fall_s;
        end
        if (wr_rise_i) rise_s <= wdata_i;
        if (wr_fall_i) fall_s <= wdata_i;
      end
    end

    p_staged_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> ($stable(rise_q) && $stable(fall_q)));
  end else begin : g_direct
    logic unused_commit;
    assign unused_commit = commit_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= '0;
        fall_q <= '0;
      end else begin
        if (wr_rise_i) rise_q <= wdata_i;
        if (wr_fall_i) fall_q <= wdata_i;
      end
    end

    p_direct_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_rise_i |=> rise_q == $past(wdata_i));
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign pwm_o  = en_i && (cnt_i >= rise_q) && (cnt_i < fall_q);

  p_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_o);
  p_equal_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_q >= fall_q) |-> !pwm_o);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int          NUM_CH      = 16,
  parameter int          CNT_W       = 16,
  parameter logic [15:0] SHADOW_MASK = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0] en_q;
  logic [CNT_W-1:0]  period_q, prescale_q, cnt;
  logic              pend_q, eop, commit, sync_set;
  logic [CNT_W-1:0]  rise_act [NUM_CH];
  logic [CNT_W-1:0]  fall_act [NUM_CH];

  assign sync_set = we_i && (addr_i == A_SYNC) && wdata_i[0];
  assign commit   = pend_q && eop;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period_q),
    .prescale_i(prescale_q),
    .cnt_o     (cnt),
    .eop_o     (eop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      period_q   <= '0;
      prescale_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (sync_set)  pend_q <= 1'b1;   // new request wins over the clearing wrap
      else if (eop)  pend_q <= 1'b0;
      if (we_i && addr_i == A_PERIOD)   period_q   <= wdata_i;
      if (we_i && addr_i == A_PRESCALE) prescale_q <= wdata_i;
      for (int i = 0; i < NUM_CH; i++) begin
        if (we_i && addr_i == A_EN_LO && i < 8)  en_q[i] <= wdata_i[i % 8];
        if (we_i && addr_i == A_EN_HI && i >= 8) en_q[i] <= wdata_i[i % 8];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_R = edge_addr(ch, 1'b0);
    localparam logic [ADDR_W-1:0] A_F = edge_addr(ch, 1'b1);
    logic ch_pwm;
    pwm_channel #(.CNT_W(CNT_W), .SHADOW(SHADOW_MASK[ch])) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_q[ch]),
      .cnt_i    (cnt),
      .wr_rise_i(we_i && addr_i == A_R),
      .wr_fall_i(we_i && addr_i == A_F),
      .wdata_i  (wdata_i),
      .commit_i (commit),
      .rise_o   (rise_act[ch]),
      .fall_o   (fall_act[ch]),
      .pwm_o    (ch_pwm)
    );
    assign pwm_o[ch] = ch_pwm;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EN_LO:    for (int i = 0; i < NUM_CH; i++) if (i < 8)  rdata_o[i % 8] = en_q[i];
      A_EN_HI:    for (int i = 0; i < NUM_CH; i++) if (i >= 8) rdata_o[i % 8] = en_q[i];
      A_PERIOD:   rdata_o = period_q;
      A_PRESCALE: rdata_o = prescale_q;
      A_SYNC:     rdata_o[0] = pend_q;
      default:
        for (int i = 0; i < NUM_CH; i++) begin
          if (addr_i == edge_addr(i, 1'b0)) rdata_o = rise_act[i];
          if (addr_i == edge_addr(i, 1'b1)) rdata_o = fall_act[i];
        end
    endcase
  end

  p_pend_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_set |=> pend_q);
  p_pend_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && eop && !sync_set) |=> !pend_q);
  p_pend_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !eop) |=> pend_q);
  p_zero_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SYNC && !wdata_i[0] && !pend_q) |=> !pend_q);
endmodule

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;
  import pwm_bank_pkg::*;
  localparam int NCH = 16;
  localparam int CW  = 16;
  localparam logic [15:0] SH = 16'hF0F0;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [5:0]  addr  = '0;
  logic [15:0] wdata = '0;
  wire  [15:0] rdata;
  wire  [15:0] pwm;

  always #2 clk = ~clk;   // 250 MHz

  pwm_bank #(.NUM_CH(NCH), .CNT_W(CW), .SHADOW_MASK(SH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .pwm_o(pwm)
  );

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit done = 1'b0;

  // reference model state
  int m_en, m_per, m_pre, m_pc, m_cnt;
  bit m_pend;
  int m_rise[NCH], m_fall[NCH], s_rise[NCH], s_fall[NCH];

  task automatic m_reset();
    m_en = 0; m_per = 0; m_pre = 0; m_pc = 0; m_cnt = 0; m_pend = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      m_rise[i] = 0; m_fall[i] = 0; s_rise[i] = 0; s_fall[i] = 0;
    end
  endtask

  task automatic m_step(int a, int d, bit w);
    bit tick, wrap, eop;
    tick = (m_pc >= m_pre);
    wrap = (m_cnt >= m_per);
    eop  = tick && wrap;
    m_pc = tick ? 0 : m_pc + 1;
    if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
    if (m_pend && eop)
      for (int i = 0; i < NCH; i++)
        if (SH[i]) begin m_rise[i] = s_rise[i]; m_fall[i] = s_fall[i]; end
    if (eop) m_pend = 1'b0;
    if (w) begin
      if (a == 0) m_en = (m_en & 'hFF00) | (d & 'hFF);
      else if (a == 1) m_en = (m_en & 'h00FF) | ((d & 'hFF) << 8);
      else if (a == 2) m_per = d;
      else if (a == 3) m_pre = d;
      else if (a == 4) begin if (d[0]) m_pend = 1'b1; end
      else if (a >= 16 && a < 16 + 2 * NCH) begin
        int ch; ch = (a - 16) / 2;
        if (SH[ch]) begin if (a[0]) s_fall[ch] = d; else s_rise[ch] = d; end
        else        begin if (a[0]) m_fall[ch] = d; else m_rise[ch] = d; end
      end
    end
  endtask

  function automatic int m_read(int a);
    if (a == 0) return m_en & 'hFF;
    if (a == 1) return (m_en >> 8) & 'hFF;
    if (a == 2) return m_per;
    if (a == 3) return m_pre;
    if (a == 4) return int'(m_pend);
    if (a >= 16 && a < 16 + 2 * NCH) return a[0] ? m_fall[(a-16)/2] : m_rise[(a-16)/2];
    return 0;
  endfunction

  function automatic int m_pwm();
    int v; v = 0;
    for (int i = 0; i < NCH; i++)
      if (m_en[i] && m_cnt >= m_rise[i] && m_cnt < m_fall[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step(int'(addr), int'(wdata), we);
    #1;
    if (!done) begin
      check("pwm_o", int'(pwm), m_pwm());
      check("rdata_o", int'(rdata), m_read(int'(addr)));
    end
  end

  task automatic wr_now(int a, int d);
    addr = 6'(a); wdata = 16'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic wr(int a, int d);
    @(negedge clk); wr_now(a, d);
  endtask
  task automatic rd(int a, output int v);
    @(negedge clk); addr = 6'(a); #1; v = int'(rdata);
  endtask
  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_eop_next();
    @(negedge clk);
    while (!(m_pc >= m_pre && m_cnt >= m_per)) @(negedge clk);
  endtask
  task automatic wait_commit();
    @(negedge clk);
    while (m_pend) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    phase = "watchdog";
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v;
    run(3);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    phase = "R1";
    rd(A_SYNC, v);   check("sync flag after reset", v, 0);
    rd(6'h10, v);    check("rise0 after reset", v, 0);
    rd(A_PERIOD, v); check("period after reset", v, 0);
    check("pwm after reset", int'(pwm), 0);
    for (int a = 0; a < 48; a++) begin @(negedge clk); addr = 6'(a); end

    // R4/R5: direct channels, several windows
    phase = "R4";
    wr(A_PERIOD, 9);
    wr(6'h10, 2); wr(6'h11, 5);        // ch0 2..5
    rd(6'h10, v); check("R5 direct rise0 readback", v, 2);
    wr(6'h12, 3); wr(6'h13, 3);        // ch1 equal -> low
    wr(6'h14, 0); wr(6'h15, 10);       // ch2 always high
    wr(6'h16, 7); wr(6'h17, 2);        // ch3 fall < rise -> low
    wr(6'h20, 1); wr(6'h21, 4);        // ch8
    phase = "R2";
    wr(A_EN_LO, 8'h0F); wr(A_EN_HI, 8'h01);
    run(40);
    phase = "R5";
    wr(6'h11, 8);
    run(25);
    phase = "R2";
    wr(A_EN_LO, 8'h0E);
    run(20);
    check("R2 ch0 disabled", int'(pwm[0]), 0);

    // R3: prescale and period change
    phase = "R3";
    wr(A_PRESCALE, 2);
    run(80);
    wr(A_PERIOD, 4);
    run(40);
    wr(A_PRESCALE, 0);
    wr(A_PERIOD, 9);
    run(20);

    // R6: staged writes are invisible
    phase = "R6";
    wr(6'h18, 1); wr(6'h19, 6);        // ch4
    wr(6'h28, 2); wr(6'h29, 8);        // ch12
    wr(A_EN_LO, 8'h1E); wr(A_EN_HI, 8'h11);
    run(40);
    rd(6'h18, v); check("R6 staged rise4 not applied", v, 0);
    check("R6 ch4 low", int'(pwm[4]), 0);

    // R10: zero write ignored
    phase = "R10";
    wr(A_SYNC, 0);
    rd(A_SYNC, v); check("R10 flag stays clear", v, 0);
    run(30);
    rd(6'h18, v); check("R10 rise4 still old", v, 0);

    // R7: commit
    phase = "R7";
    wr(A_SYNC, 1);
    rd(A_SYNC, v); check("R7 flag pending", v, 1);
    wait_commit();
    rd(6'h18, v); check("R7 rise4 committed", v, 1);
    rd(6'h29, v); check("R7 fall12 committed", v, 8);
    rd(A_SYNC, v); check("R7 flag cleared", v, 0);
    run(30);

    // R8: request before values is consumed
    phase = "R8";
    wr(A_SYNC, 1);
    wait_commit();
    wr(6'h1A, 2); wr(6'h1B, 7);        // ch5
    wr(A_EN_LO, 8'h3E);
    run(40);
    rd(6'h1A, v); check("R8 late rise5 pending", v, 0);
    wr(A_SYNC, 1);
    wait_commit();
    rd(6'h1A, v); check("R8 rise5 after second request", v, 2);
    run(20);

    // R9: coincidences with the wrap
    phase = "R9";
    wait_eop_next();
    wr_now(A_SYNC, 1);
    rd(A_SYNC, v); check("R9 request on wrap kept", v, 1);
    wait_commit();
    wr(6'h1C, 3); wr(6'h1D, 9);        // ch6 staged
    wr(A_EN_LO, 8'h7E);
    wr(A_SYNC, 1);
    wait_eop_next();
    wr_now(6'h1C, 5);                  // lands with the commit
    rd(6'h1C, v); check("R9 commit took older stage", v, 3);
    run(25);
    wr(A_SYNC, 1);
    wait_commit();
    rd(6'h1C, v); check("R9 coincident write later applied", v, 5);
    run(30);

    finish_run();
  end
endmodule